// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the control core of a small vending machine. It keeps a running credit built from one-cycle coin pulses worth 5, 10 and 25 cents, and it sells one of three priced items when a selection pulse arrives and the money is enough. All change goes back as a count of nickels. A coin may land in the same cycle as a selection, and that coin counts toward the purchase. A coin-return button refunds the whole credit and closes the coin slot for that cycle.

Credit is held as a one-hot state over the levels 0 to 25 cents in nickel steps, and it saturates at the cap. A coin that would take the credit past the cap is refunded at once, in full or in part. More than one coin line high in one cycle is treated as a jam and all coins are ignored. More than one selection line high is ignored in the same way. All outputs are registered. The inputs sampled at a rising edge produce the new credit, the dispensed-item code and the change count right after that edge. The item code and change last for one cycle.

Top module: `vend_ctrl`

## Requirements
- R1: While `init` is high at a rising edge, the credit becomes 0, `item_out` becomes 0 (none) and `change_nickels` becomes 0.
- R2: With no return, no valid selection and a single coin, the credit rises by the coin value (nickel 5, dime 10, quarter 25) if the total stays within 25, and the change is 0.
- R3: When credit plus a single coin exceeds 25 with no sale, the credit becomes 25 and `change_nickels` equals the excess divided by 5 in that same cycle. At credit 25, for example, a quarter gives change 5, and 20 plus a quarter gives change 4.
- R4: When two or more coin lines are high in one cycle, no coin is accepted. The credit does not change from coins, and no coin is refunded.
- R5: When two or more selection lines are high in one cycle, nothing is dispensed. A single valid coin in that cycle is still handled as in R2 and R3.
- R6: With a single selection and money (credit plus a valid coin) at or above the price (gum 15, apple 20, yogurt 25), `item_out` shows the item (gum 1, apple 2, yogurt 3) and `change_nickels` = (money − price)/5. The credit becomes 0.
- R7: With a single selection and money below its price, `item_out` stays 0 and the money is kept as credit, capped as in R3.
- R8: When `refund_btn` is high, `change_nickels` = credit/5 and the credit becomes 0. Any coin and any selection in that cycle are ignored, and `item_out` stays 0.
- R9: `item_out` and `change_nickels` are non-zero only in the cycle right after the edge that produced the sale or refund. The internal credit state is always one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| init | input | 1 | Synchronous initialise, active high |
| coin_nickel | input | 1 | One-cycle pulse: 5-cent coin deposited |
| coin_dime | input | 1 | One-cycle pulse: 10-cent coin deposited |
| coin_quarter | input | 1 | One-cycle pulse: 25-cent coin deposited |
| refund_btn | input | 1 | Coin-return button |
| pick_gum | input | 1 | Gum selection button |
| pick_apple | input | 1 | Apple selection button |
| pick_yogurt | input | 1 | Yogurt selection button |
| credit_cents | output | 5 | Current credit in cents |
| item_out | output | 2 | Item dispensed this cycle: 0 none, 1 gum, 2 apple, 3 yogurt |
| change_nickels | output | 3 | Nickels returned this cycle |

## Verification
The hardest situations arise when several rules meet in one cycle. One is a quarter arriving at full credit together with a selection, which gives the largest possible change of 7 nickels. Another is a return press alongside a coin and a selection, where return must win and the coin must vanish. Directed sequences first build the credit to each level and then apply these combined inputs. Jammed coin and selection patterns are also mixed in at full and partial credit. A long stretch of weighted random pulses, compared every cycle against a behavioural model, then covers the remaining combinations.

// File: rtl/vend_pkg.sv
package vend_pkg;

   typedef enum logic [1:0] {
      ITEM_NONE   = 2'd0,
      ITEM_GUM    = 2'd1,
      ITEM_APPLE  = 2'd2,
      ITEM_YOGURT = 2'd3
   } item_e;

   localparam int unsigned NUM_COINS = 3;
   localparam int unsigned NUM_ITEMS = 3;
   localparam int unsigned CENTS_PER_UNIT = 5;

   // coin value in nickel units, index 0 nickel, 1 dime, 2 quarter
   function automatic int unsigned coin_units(input int unsigned idx);
      case (idx)
         0: return 1;
         1: return 2;
         default: return 5;
      endcase
   endfunction

   function automatic item_e item_code(input int unsigned idx);
      case (idx)
         0: return ITEM_GUM;
         1: return ITEM_APPLE;
         default: return ITEM_YOGURT;
      endcase
   endfunction

endpackage

// File: rtl/vend_pulse_decode.sv
module vend_pulse_decode #(
   parameter int unsigned LINES = 3
) (
   input  logic [LINES-1:0] raw,
   output logic             single,
   output logic [LINES-1:0] picked
);
   localparam int unsigned CNT_W = $clog2(LINES + 1);

   logic [CNT_W-1:0] ones;

   if (LINES < 2) begin : g_bad_lines
      $error("vend_pulse_decode needs at least two lines");
   end

   always_comb begin
      ones = '0;
      for (int i = 0; i < LINES; i++) begin
         ones = ones + CNT_W'(raw[i]);
      end
   end

   assign single = (ones == CNT_W'(1));

   for (genvar g = 0; g < LINES; g++) begin : g_line
      assign picked[g] = raw[g] & single;
   end

endmodule

// File: rtl/vend_settle.sv
module vend_settle
   import vend_pkg::*;
#(
   parameter int unsigned CAP_UNITS = 5,
   parameter int unsigned LVL_W     = 3,
   parameter int unsigned AVAIL_W   = 4,
   parameter int unsigned CHANGE_W  = 3,
   parameter int unsigned PRICE_GUM    = 3,
   parameter int unsigned PRICE_APPLE  = 4,
   parameter int unsigned PRICE_YOGURT = 5
) (
   input  logic [LVL_W-1:0]     level,
   input  logic [NUM_COINS-1:0] coin_hit,
   input  logic [NUM_ITEMS-1:0] pick_hit,
   input  logic                 refund,
   output logic [LVL_W-1:0]     target,
   output logic [CHANGE_W-1:0]  change,
   output item_e                item
);
   logic [AVAIL_W-1:0] coin_val;
   logic [AVAIL_W-1:0] price;
   logic [AVAIL_W-1:0] avail;
   logic               any_pick;
   item_e              pick_code;

   function automatic int unsigned price_of(input int unsigned idx);
      case (idx)
         0: return PRICE_GUM;
         1: return PRICE_APPLE;
         default: return PRICE_YOGURT;
      endcase
   endfunction

   always_comb begin
      coin_val = '0;
      for (int i = 0; i < NUM_COINS; i++) begin
         if (coin_hit[i]) coin_val = AVAIL_W'(coin_units(i));
      end
   end

   always_comb begin
      price     = '0;
      pick_code = ITEM_NONE;
      any_pick  = 1'b0;
      for (int i = 0; i < NUM_ITEMS; i++) begin
         if (pick_hit[i]) begin
            price     = AVAIL_W'(price_of(i));
            pick_code = item_code(i);
            any_pick  = 1'b1;
         end
      end
   end

   assign avail = AVAIL_W'(level) + coin_val;

   always_comb begin
      target = level;
      change = '0;
      item   = ITEM_NONE;
      if (refund) begin
         target = '0;
         change = CHANGE_W'(level);
      end else if (any_pick && (avail >= price)) begin
         target = '0;
         change = CHANGE_W'(avail - price);
         item   = pick_code;
      end else if (avail > AVAIL_W'(CAP_UNITS)) begin
         target = LVL_W'(CAP_UNITS);
         change = CHANGE_W'(avail - AVAIL_W'(CAP_UNITS));
      end else begin
         target = LVL_W'(avail);
      end
   end

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm #(
   parameter int unsigned CAP_UNITS = 5,
   parameter int unsigned LVL_W     = 3
) (
   input  logic             clk,
   input  logic             init,
   input  logic [LVL_W-1:0] target,
   output logic [LVL_W-1:0] level
);
   localparam int unsigned STATES = CAP_UNITS + 1;

   logic [STATES-1:0] hot_q;
   logic [STATES-1:0] hot_d;

   if ((1 << LVL_W) < STATES) begin : g_bad_width
      $error("vend_credit_fsm level width too small for the cap");
   end

   for (genvar g = 0; g < STATES; g++) begin : g_state
      assign hot_d[g] = (target == LVL_W'(g));
      always_ff @(posedge clk) begin
         if (init) hot_q[g] <= (g == 0);
         else      hot_q[g] <= hot_d[g];
      end
   end

   always_comb begin
      level = '0;
      for (int i = 0; i < STATES; i++) begin
         if (hot_q[i]) level = level | LVL_W'(i);
      end
   end

   // R9: exactly one credit state active at all times after initialise
   a_r9_onehot_state: assert property (@(posedge clk) disable iff (init)
      $onehot(hot_q));

   // R3: the requested level never goes beyond the cap
   a_r3_target_in_range: assert property (@(posedge clk) disable iff (init)
      target <= LVL_W'(CAP_UNITS));

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
#(
   parameter int unsigned CAP_UNITS    = 5,
   parameter int unsigned PRICE_GUM    = 3,
   parameter int unsigned PRICE_APPLE  = 4,
   parameter int unsigned PRICE_YOGURT = 5,
   parameter int unsigned CHANGE_W     = 3,
   localparam int unsigned CENTS_W = $clog2(CAP_UNITS * CENTS_PER_UNIT + 1)
) (
   input  logic                clk,
   input  logic                init,
   input  logic                coin_nickel,
   input  logic                coin_dime,
   input  logic                coin_quarter,
   input  logic                refund_btn,
   input  logic                pick_gum,
   input  logic                pick_apple,
   input  logic                pick_yogurt,
   output logic [CENTS_W-1:0]  credit_cents,
   output logic [1:0]          item_out,
   output logic [CHANGE_W-1:0] change_nickels
);
   localparam int unsigned LVL_W    = $clog2(CAP_UNITS + 1);
   localparam int unsigned MAX_AV   = CAP_UNITS + 5;
   localparam int unsigned AVAIL_W  = $clog2(MAX_AV + 1);
   localparam int unsigned MIN_PRICE =
      (PRICE_GUM < PRICE_APPLE) ?
         ((PRICE_GUM < PRICE_YOGURT) ? PRICE_GUM : PRICE_YOGURT) :
         ((PRICE_APPLE < PRICE_YOGURT) ? PRICE_APPLE : PRICE_YOGURT);
   localparam int unsigned MAX_CHANGE = MAX_AV - MIN_PRICE;

   if (PRICE_GUM > CAP_UNITS || PRICE_APPLE > CAP_UNITS || PRICE_YOGURT > CAP_UNITS) begin : g_bad_price
      $error("vend_ctrl: every price must be reachable within the credit cap");
   end
   if (MIN_PRICE == 0) begin : g_bad_zero
      $error("vend_ctrl: prices must be non-zero");
   end
   if (MAX_CHANGE >= (1 << CHANGE_W) || MAX_AV - CAP_UNITS >= (1 << CHANGE_W)) begin : g_bad_change
      $error("vend_ctrl: change width cannot hold the largest refund");
   end

   logic [NUM_COINS-1:0] coin_raw, coin_hit;
   logic [NUM_ITEMS-1:0] pick_raw, pick_hit;
   logic                 coin_single, pick_single;
   logic [LVL_W-1:0]     level, target;
   logic [CHANGE_W-1:0]  change_d, change_q;
   item_e                item_d, item_q;

   assign coin_raw = {coin_quarter, coin_dime, coin_nickel};
   assign pick_raw = {pick_yogurt, pick_apple, pick_gum};

   vend_pulse_decode #(.LINES(NUM_COINS)) u_coin_dec (
      .raw(coin_raw), .single(coin_single), .picked(coin_hit)
   );

   vend_pulse_decode #(.LINES(NUM_ITEMS)) u_pick_dec (
      .raw(pick_raw), .single(pick_single), .picked(pick_hit)
   );

   vend_settle #(
      .CAP_UNITS(CAP_UNITS), .LVL_W(LVL_W), .AVAIL_W(AVAIL_W), .CHANGE_W(CHANGE_W),
      .PRICE_GUM(PRICE_GUM), .PRICE_APPLE(PRICE_APPLE), .PRICE_YOGURT(PRICE_YOGURT)
   ) u_settle (
      .level(level), .coin_hit(coin_hit), .pick_hit(pick_hit), .refund(refund_btn),
      .target(target), .change(change_d), .item(item_d)
   );

   vend_credit_fsm #(.CAP_UNITS(CAP_UNITS), .LVL_W(LVL_W)) u_fsm (
      .clk(clk), .init(init), .target(target), .level(level)
   );

   always_ff @(posedge clk) begin
      if (init) begin
         change_q <= '0;
         item_q   <= ITEM_NONE;
      end else begin
         change_q <= change_d;
         item_q   <= item_d;
      end
   end

   assign credit_cents   = (CENTS_W'(level) << 2) + CENTS_W'(level);
   assign item_out       = item_q;
   assign change_nickels = change_q;

   // R3: credit never shown above the cap
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (init)
      credit_cents <= CENTS_W'(CAP_UNITS * CENTS_PER_UNIT));

   // R8: return clears credit and blocks any sale
   a_r8_return_clears: assert property (@(posedge clk) disable iff (init)
      refund_btn |=> (credit_cents == '0) && (item_out == ITEM_NONE));

   // R6: a sale always leaves zero credit
   a_r6_sale_zero_credit: assert property (@(posedge clk) disable iff (init)
      (item_out != ITEM_NONE) |-> (credit_cents == '0));

   // R5: a multi-selection never dispenses
   a_r5_multi_pick: assert property (@(posedge clk) disable iff (init)
      ($countones(pick_raw) > 1) |=> (item_out == ITEM_NONE));

   // R4: jammed coins with nothing else leave credit untouched and refund nothing
   a_r4_jam_ignored: assert property (@(posedge clk) disable iff (init)
      (($countones(coin_raw) > 1) && !refund_btn && (pick_raw == '0))
         |=> ($stable(credit_cents) && (change_nickels == '0)));

endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
   logic clk = 1'b0;
   logic init = 1'b1;
   logic c_n = 0, c_d = 0, c_q = 0, rb = 0, p_g = 0, p_a = 0, p_y = 0;
   logic [4:0] credit_cents;
   logic [1:0] item_out;
   logic [2:0] change_nickels;

   int total = 0;
   int bad = 0;
   int m_credit = 0;
   int m_item = 0;
   int m_change = 0;
   string m_tag = "R1";
   bit done = 0;

   always #10 clk = ~clk;

   vend_ctrl dut (
      .clk(clk), .init(init), .coin_nickel(c_n), .coin_dime(c_d), .coin_quarter(c_q),
      .refund_btn(rb), .pick_gum(p_g), .pick_apple(p_a), .pick_yogurt(p_y),
      .credit_cents(credit_cents), .item_out(item_out), .change_nickels(change_nickels)
   );

   task automatic compare();
      total++;
      if (credit_cents != m_credit || item_out != m_item || change_nickels != m_change) begin
         bad++;
         $display("FAIL %s: credit=%0d item=%0d change=%0d expected credit=%0d item=%0d change=%0d",
                  m_tag, credit_cents, item_out, change_nickels, m_credit, m_item, m_change);
      end
   endtask

   // behavioural reference for one rising edge
   task automatic model();
      int nc, ns, cv, pr, code, av;
      nc = c_n + c_d + c_q;
      ns = p_g + p_a + p_y;
      if (init) begin
         m_credit = 0; m_item = 0; m_change = 0; m_tag = "R1";
         return;
      end
      if (rb) begin
         m_change = m_credit / 5; m_credit = 0; m_item = 0; m_tag = "R8";
         return;
      end
      cv = 0;
      if (nc == 1) cv = c_n ? 5 : (c_d ? 10 : 25);
      pr = 0; code = 0;
      if (ns == 1) begin
         if (p_g) begin pr = 15; code = 1; end
         else if (p_a) begin pr = 20; code = 2; end
         else begin pr = 25; code = 3; end
      end
      av = m_credit + cv;
      if (ns > 1) m_tag = "R5";
      else if (nc > 1) m_tag = "R4";
      else if (ns == 1 && av >= pr) m_tag = "R6";
      else if (ns == 1) m_tag = "R7";
      else if (av > 25) m_tag = "R3";
      else if (nc == 1) m_tag = "R2";
      else m_tag = "R9";
      if (code != 0 && av >= pr) begin
         m_item = code; m_change = (av - pr) / 5; m_credit = 0;
      end else if (av > 25) begin
         m_item = 0; m_change = (av - 25) / 5; m_credit = 25;
      end else begin
         m_item = 0; m_change = 0; m_credit = av;
      end
   endtask

   // drive at negedge, model at posedge, check at next negedge
   task automatic step(input logic [6:0] v);
      {c_n, c_d, c_q, rb, p_g, p_a, p_y} = v;
      @(posedge clk);
      model();
      @(negedge clk);
      compare();
   endtask

   localparam logic [6:0] N = 7'b1000000, D = 7'b0100000, Q = 7'b0010000,
                          RT = 7'b0001000, G = 7'b0000100, A = 7'b0000010,
                          Y = 7'b0000001, IDLE = 7'b0;

   initial begin
      @(negedge clk);
      step(IDLE);             // R1 reset state
      step(IDLE);
      init = 0;
      step(N); step(N); step(N);       // R2 build to 15
      step(G);                          // R6 gum exact
      step(IDLE);                       // R9 outputs back to zero
      step(D); step(A);                 // R7 not enough for apple
      step(D); step(A);                 // R6 apple exact
      step(Q); step(Q);                 // R3 full credit plus quarter -> change 5
      step(Q | G);                      // R6 max change 7
      step(N | D); step(N | Q | D);     // R4 jams at zero
      step(Q); step(N | D);             // R4 jam at 25
      step(A | Y);                      // R5 multi-select
      step(N | G | Y);                  // R5 coin still refunded at cap
      step(RT);                         // R8 refund 5 nickels
      step(D); step(D); step(Q);        // R3 20 + quarter -> change 4
      step(RT | Q | Y);                 // R8 return beats coin and select
      step(N); step(RT | D);            // R8 coin blocked
      step(D | Y);                      // R7 short for yogurt
      step(Q | Y);                      // R6 coin with yogurt
      step(IDLE);                       // R9
      init = 1; step(Q); init = 0;      // R1 initialise mid-run
      for (int k = 0; k < 600; k++) begin
         logic [6:0] v;
         v = '0;
         if ($urandom % 3 == 0) v[6 - ($urandom % 3)] = 1'b1;
         if ($urandom % 9 == 0) v[6 - ($urandom % 3)] = 1'b1;
         if ($urandom % 4 == 0) v[2 - ($urandom % 3)] = 1'b1;
         if ($urandom % 12 == 0) v[2 - ($urandom % 3)] = 1'b1;
         if ($urandom % 15 == 0) v[3] = 1'b1;
         step(v);
      end
      done = 1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule